// File: doc/BRIEF.md
# Character LCD Cursor and Display Shifter

This block carries out the shift command of a character display controller. A host write with both register-select and read/write low is decoded. When its upper nibble selects the shift command, the block either steps the cursor address or rotates the visible window of both display lines. Bit 3 of the data picks cursor or display, and bit 2 picks the direction. The two low bits carry no meaning. The cursor address also sets the blink position, so moving one moves the other.

A cursor step moves the address counter by one. Its wrap points depend on the line mode input. In two-line mode, line 1 covers addresses 0x00 to 0x27 and line 2 covers 0x40 to 0x67. A display shift leaves the address counter alone and rotates a per-line window offset modulo 40. The cursor therefore travels on screen together with the text. Each line rotates inside itself, so nothing crosses from one line to the other. No offset exists for the auxiliary symbol area, so a display shift never moves it.

A busy flag covers the execution time. It is counted in pulses of a single-cycle oscillator tick input, ten of them by default. Writes that arrive while busy is high are dropped.

Top module: `lcd_shift_engine`

## Requirements
- R1: After reset, the address is 0x00, both line offsets are 0, and busy is low.
- R2: A write is accepted only when wr_en=1, rs=0, rw=0, data[7:4]=4'b0001 and busy is low. Any other write leaves the address, the offsets and busy unchanged. The values of data[1:0] never matter.
- R3: A cursor-right command (data[3]=0, data[2]=1) raises the address by one in the cycle after acceptance, except at the wrap points of R5 and R6.
- R4: A cursor-left command (data[3]=0, data[2]=0) lowers the address by one in the cycle after acceptance, except at the wrap points of R5 and R6.
- R5: With two_line=1, cursor-right moves 0x27 to 0x40 and 0x67 to 0x00. Cursor-left moves 0x40 to 0x27 and 0x00 to 0x67.
- R6: With two_line=0, the address runs from 0x00 to 0x4F. Cursor-right moves 0x4F to 0x00, and cursor-left moves 0x00 to 0x4F.
- R7: A display command (data[3]=1) leaves the address unchanged. With data[2]=0 (window left), each line offset rises by one modulo 40, so 39 goes to 0. With data[2]=1 (window right), each offset falls by one, so 0 goes to 39. The offsets always stay below 40.
- R8: Busy rises in the cycle after an accepted command. It falls in the cycle after the tenth osc_tick pulse counted while busy is high.
- R9: A write that arrives while busy is high has no effect. This includes a write in the same cycle as the final osc_tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| rs | input | 1 | Register select, 0 for instructions |
| rw | input | 1 | Read/write, 0 for a write |
| data | input | 8 | Instruction byte |
| two_line | input | 1 | 1 selects two-line addressing |
| osc_tick | input | 1 | One-cycle pulse for each display oscillator period |
| addr | output | 7 | Cursor and blink address |
| ofs_line1 | output | 6 | Window offset of line 1 |
| ofs_line2 | output | 6 | Window offset of line 2 |
| busy | output | 1 | Command execution in progress |

## Verification
The final oscillator tick of a busy period and a new host write can land in the same clock cycle. The busy timer then has to end its count while the decoder decides whether to accept the write. The bench provokes this by holding osc_tick through nine pulses and then raising wr_en with a cursor-right command on the tenth pulse. It judges the outcome at the ports: the address must be unchanged and busy must be low afterwards, which shows the write was dropped and did not restart the timer. A mid-busy write is checked the same way.

// File: rtl/lcd_shift_pkg.sv
package lcd_shift_pkg;

    localparam logic [3:0] SHIFT_OPCODE = 4'b0001;

    // encoding equals {data[3], data[2]}
    typedef enum logic [1:0] {
        OP_CUR_LEFT   = 2'b00,
        OP_CUR_RIGHT  = 2'b01,
        OP_DISP_LEFT  = 2'b10,
        OP_DISP_RIGHT = 2'b11
    } shift_op_e;

    typedef struct packed {
        logic      valid;
        shift_op_e op;
    } shift_cmd_t;

    function automatic logic is_shift_write(input logic wr, input logic rs,
                                            input logic rw, input logic [7:0] d);
        return wr && !rs && !rw && (d[7:4] == SHIFT_OPCODE);
    endfunction

    function automatic shift_op_e op_of(input logic [7:0] d);
        return shift_op_e'(d[3:2]);
    endfunction

endpackage

// File: rtl/lcd_shift_decode.sv
module lcd_shift_decode
    import lcd_shift_pkg::*;
(
    input  logic       wr_en,
    input  logic       rs,
    input  logic       rw,
    input  logic [7:0] data,
    input  logic       busy,
    output shift_cmd_t cmd
);

    always_comb begin
        cmd.valid = is_shift_write(wr_en, rs, rw, data) && !busy;
        cmd.op    = op_of(data);
    end

endmodule

// File: rtl/lcd_cursor_ctr.sv
module lcd_cursor_ctr
    import lcd_shift_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  shift_cmd_t        cmd,
    input  logic              two_line,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] L1_LAST  = ADDR_W'(LINE_LEN - 1);
    localparam logic [ADDR_W-1:0] L2_FIRST = ADDR_W'(LINE2_BASE);
    localparam logic [ADDR_W-1:0] L2_LAST  = ADDR_W'(LINE2_BASE + LINE_LEN - 1);
    localparam logic [ADDR_W-1:0] ONE_LAST = ADDR_W'(2 * LINE_LEN - 1);
    localparam logic [ADDR_W-1:0] ONE      = ADDR_W'(1);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (cmd.valid && cmd.op == OP_CUR_RIGHT) begin
            if (two_line) begin
                if (addr_q == L1_LAST)       addr_d = L2_FIRST;
                else if (addr_q >= L2_LAST)  addr_d = '0;
                else                         addr_d = addr_q + ONE;
            end else begin
                addr_d = (addr_q >= ONE_LAST) ? '0 : addr_q + ONE;
            end
        end else if (cmd.valid && cmd.op == OP_CUR_LEFT) begin
            if (two_line) begin
                if (addr_q == '0)            addr_d = L2_LAST;
                else if (addr_q == L2_FIRST) addr_d = L1_LAST;
                else                         addr_d = addr_q - ONE;
            end else begin
                addr_d = (addr_q == '0) ? ONE_LAST : addr_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    assign addr = addr_q;

endmodule

// File: rtl/lcd_offset_rot.sv
module lcd_offset_rot
    import lcd_shift_pkg::*;
#(
    parameter int LINE_LEN = 40,
    parameter int OFS_W    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  shift_cmd_t       cmd,
    output logic [OFS_W-1:0] ofs
);

    localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(LINE_LEN - 1);
    localparam logic [OFS_W-1:0] ONE      = OFS_W'(1);

    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] ofs_d;

    always_comb begin
        ofs_d = ofs_q;
        if (cmd.valid && cmd.op == OP_DISP_LEFT)
            ofs_d = (ofs_q >= OFS_LAST) ? '0 : ofs_q + ONE;
        else if (cmd.valid && cmd.op == OP_DISP_RIGHT)
            ofs_d = (ofs_q == '0) ? OFS_LAST : ofs_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) ofs_q <= '0;
        else     ofs_q <= ofs_d;
    end

    assign ofs = ofs_q;

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
    parameter int BUSY_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic osc_tick,
    output logic busy
);

    localparam int CNT_W = (BUSY_TICKS > 2) ? $clog2(BUSY_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BUSY_TICKS - 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q && osc_tick) begin
            if (cnt_q == CNT_LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/lcd_shift_engine.sv
module lcd_shift_engine
    import lcd_shift_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int LINE_LEN   = 40,
    parameter int LINE2_BASE = 64,
    parameter int OFS_W      = 6,
    parameter int BUSY_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rs,
    input  logic              rw,
    input  logic [7:0]        data,
    input  logic              two_line,
    input  logic              osc_tick,
    output logic [ADDR_W-1:0] addr,
    output logic [OFS_W-1:0]  ofs_line1,
    output logic [OFS_W-1:0]  ofs_line2,
    output logic              busy
);

    localparam int NUM_LINES = 2;

    shift_cmd_t       cmd;
    logic [OFS_W-1:0] line_ofs [NUM_LINES];

    lcd_shift_decode u_dec (
        .wr_en (wr_en),
        .rs    (rs),
        .rw    (rw),
        .data  (data),
        .busy  (busy),
        .cmd   (cmd)
    );

    lcd_cursor_ctr #(
        .ADDR_W     (ADDR_W),
        .LINE_LEN   (LINE_LEN),
        .LINE2_BASE (LINE2_BASE)
    ) u_cur (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .two_line (two_line),
        .addr     (addr)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        lcd_offset_rot #(
            .LINE_LEN (LINE_LEN),
            .OFS_W    (OFS_W)
        ) u_rot (
            .clk (clk),
            .rst (rst),
            .cmd (cmd),
            .ofs (line_ofs[g])
        );
    end

    lcd_busy_timer #(
        .BUSY_TICKS (BUSY_TICKS)
    ) u_busy (
        .clk      (clk),
        .rst      (rst),
        .start    (cmd.valid),
        .osc_tick (osc_tick),
        .busy     (busy)
    );

    assign ofs_line1 = line_ofs[0];
    assign ofs_line2 = line_ofs[1];

endmodule

// File: rtl/lcd_shift_chk.sv
module lcd_shift_chk #(
    parameter int ADDR_W   = 7,
    parameter int LINE_LEN = 40,
    parameter int OFS_W    = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rs,
    input logic              rw,
    input logic [7:0]        data,
    input logic              two_line,
    input logic              osc_tick,
    input logic [ADDR_W-1:0] addr,
    input logic [OFS_W-1:0]  ofs_line1,
    input logic [OFS_W-1:0]  ofs_line2,
    input logic              busy
);

    logic take;
    assign take = wr_en && !rs && !rw && (data[7:4] == 4'b0001) && !busy;

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (addr == '0 && ofs_line1 == '0 && ofs_line2 == '0 && !busy));

    // R2
    foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy && (rs || rw || data[7:4] != 4'b0001))
        |=> ($stable(addr) && $stable(ofs_line1) && $stable(ofs_line2) && !busy));

    // R3
    cursor_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (take && data[3:2] == 2'b01 && !two_line && addr < ADDR_W'(2 * LINE_LEN - 1))
        |=> (addr == ADDR_W'($past(addr) + 1'b1)));

    // R7
    disp_keeps_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (take && data[3]) |=> $stable(addr));

    // R7
    ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
        (ofs_line1 < OFS_W'(LINE_LEN) && ofs_line2 < OFS_W'(LINE_LEN)));

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> busy);

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(osc_tick));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(addr) && $stable(ofs_line1) && $stable(ofs_line2)));

endmodule

bind lcd_shift_engine lcd_shift_chk #(
    .ADDR_W   (ADDR_W),
    .LINE_LEN (LINE_LEN),
    .OFS_W    (OFS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rs        (rs),
    .rw        (rw),
    .data      (data),
    .two_line  (two_line),
    .osc_tick  (osc_tick),
    .addr      (addr),
    .ofs_line1 (ofs_line1),
    .ofs_line2 (ofs_line2),
    .busy      (busy)
);

// File: tb/sim_lcd_shift_engine.sv
module sim_lcd_shift_engine;

    localparam int CLK_PERIOD = 10;
    localparam int TICKS      = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       rs = 1'b0;
    logic       rw = 1'b0;
    logic [7:0] data = 8'h00;
    logic       two_line = 1'b0;
    logic       osc_tick = 1'b0;
    logic [6:0] addr;
    logic [5:0] ofs_line1;
    logic [5:0] ofs_line2;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int exp_addr = 0;
    int exp_ofs  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lcd_shift_engine u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rs        (rs),
        .rw        (rw),
        .data      (data),
        .two_line  (two_line),
        .osc_tick  (osc_tick),
        .addr      (addr),
        .ofs_line1 (ofs_line1),
        .ofs_line2 (ofs_line2),
        .busy      (busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        check({req, " addr"}, int'(addr), exp_addr);
        check({req, " ofs1"}, int'(ofs_line1), exp_ofs);
        check({req, " ofs2"}, int'(ofs_line2), exp_ofs);
    endtask

    // one write cycle; outputs are updated when this returns
    task automatic write(input logic [7:0] d, input logic r_s, input logic r_w);
        @(negedge clk);
        wr_en = 1'b1; data = d; rs = r_s; rw = r_w;
        @(negedge clk);
        wr_en = 1'b0; rs = 1'b0; rw = 1'b0;
    endtask

    task automatic ticks(input int n);
        osc_tick = 1'b1;
        repeat (n) @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] d);
        write(d, 1'b0, 1'b0);
        ticks(TICKS);
    endtask

    function automatic int step_addr(input int a, input bit right, input bit two);
        if (two) begin
            if (right) return (a == 8'h27) ? 8'h40 : (a == 8'h67) ? 0 : a + 1;
            return (a == 8'h40) ? 8'h27 : (a == 0) ? 8'h67 : a - 1;
        end
        if (right) return (a == 8'h4F) ? 0 : a + 1;
        return (a == 0) ? 8'h4F : a - 1;
    endfunction

    task automatic t_reset;
        @(negedge clk);
        exp_addr = 0; exp_ofs = 0;
        check_state("R1");
        check("R1 busy", int'(busy), 0);
    endtask

    task automatic t_cursor_1line;
        two_line = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cmd(8'h14);
            exp_addr = step_addr(exp_addr, 1'b1, 1'b0);
            check_state("R3 right");
        end
        cmd(8'h10);
        exp_addr = step_addr(exp_addr, 1'b0, 1'b0);
        check_state("R4 left");
        check("R4 value", int'(addr), 2);
    endtask

    task automatic t_wrap_1line;
        two_line = 1'b0;
        while (exp_addr != 0) begin
            cmd(8'h10);
            exp_addr = step_addr(exp_addr, 1'b0, 1'b0);
        end
        check_state("R4 to zero");
        cmd(8'h10);
        exp_addr = 8'h4F;
        check_state("R6 0x00 left");
        cmd(8'h14);
        exp_addr = 0;
        check_state("R6 0x4F right");
    endtask

    task automatic t_wrap_2line;
        two_line = 1'b1;
        cmd(8'h10);
        exp_addr = 8'h67;
        check_state("R5 0x00 left");
        cmd(8'h14);
        exp_addr = 0;
        check_state("R5 0x67 right");
        for (int i = 0; i < 39; i++) begin
            cmd(8'h14);
            exp_addr = step_addr(exp_addr, 1'b1, 1'b1);
        end
        check("R3 reach 0x27", int'(addr), 8'h27);
        cmd(8'h14);
        exp_addr = 8'h40;
        check_state("R5 0x27 right");
        cmd(8'h10);
        exp_addr = 8'h27;
        check_state("R5 0x40 left");
    endtask

    task automatic t_display;
        cmd(8'h18);
        exp_ofs = 1;
        check_state("R7 window left");
        cmd(8'h1C);
        exp_ofs = 0;
        check_state("R7 window right");
        cmd(8'h1F);
        exp_ofs = 39;
        check_state("R7 wrap 0 to 39, low bits ignored R2");
        cmd(8'h1B);
        exp_ofs = 0;
        check_state("R7 wrap 39 to 0, low bits ignored R2");
    endtask

    task automatic t_ignored;
        write(8'h14, 1'b1, 1'b0);
        check_state("R2 rs high");
        check("R2 rs busy", int'(busy), 0);
        write(8'h14, 1'b0, 1'b1);
        check_state("R2 rw high");
        check("R2 rw busy", int'(busy), 0);
        write(8'h24, 1'b0, 1'b0);
        check_state("R2 other opcode");
        check("R2 opcode busy", int'(busy), 0);
        @(negedge clk);
        data = 8'h14;
        @(negedge clk);
        check_state("R2 no strobe");
        check("R2 strobe busy", int'(busy), 0);
        cmd(8'h17);
        exp_addr = step_addr(exp_addr, 1'b1, two_line);
        exp_ofs  = 0;
        check_state("R2 low bits are not a mode");
    endtask

    task automatic t_busy;
        write(8'h14, 1'b0, 1'b0);
        exp_addr = step_addr(exp_addr, 1'b1, two_line);
        check("R8 busy rises", int'(busy), 1);
        @(negedge clk);
        check("R8 no tick hold", int'(busy), 1);
        ticks(TICKS - 1);
        check("R8 one tick short", int'(busy), 1);
        ticks(1);
        check("R8 busy falls", int'(busy), 0);
        check_state("R8 addr");
    endtask

    task automatic t_collision;
        write(8'h14, 1'b0, 1'b0);
        exp_addr = step_addr(exp_addr, 1'b1, two_line);
        ticks(3);
        write(8'h18, 1'b0, 1'b0);
        check_state("R9 mid-busy write");
        check("R9 still busy", int'(busy), 1);
        ticks(TICKS - 4);
        @(negedge clk);
        osc_tick = 1'b1; wr_en = 1'b1; data = 8'h14;
        @(negedge clk);
        osc_tick = 1'b0; wr_en = 1'b0;
        check_state("R9 write on final tick");
        check("R9 busy after final tick", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cursor_1line();
        t_wrap_1line();
        t_wrap_2line();
        t_display();
        t_ignored();
        t_busy();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule